// File: doc/BRIEF.md
# Platform Power State Transition Controller

This block is the state machine that follows the platform through its running, processor-idle, sleep, soft-off and unpowered conditions. It moves between them when trigger events arrive. Triggers come in as single-cycle pulses: a processor halt, reads of the idle-level registers for levels 2, 3 and 4, a sleep-enable carrying a requested sleep type, a power-button override, any enabled break event and the stop-clock request. The power-fail indication is a level. The block reports the current state as a 4-bit code and drives three controls: clock stop, processor stop and a processor low-voltage request.

The deepest idle state is chosen by two configuration bits and the live bus-master activity level. Inside that state the block orders the controls. The processor is stopped first and the voltage is lowered only after that. On a break event the voltage is restored, and the processor stop is held for a parameterised number of cycles before the block returns to running. When power comes back from the unpowered state, the target depends on an after-power-loss bit and on whether the platform was in soft-off before the loss. Wake decoding, register bus access and regulator control are left to neighbouring logic.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state code is 0 (C0, running) and the clock-stop, processor-stop and low-voltage outputs are all 0. The state codes are C0=0, C1=1, C2=2, C3=3, C4=4, S1=5, S3=6, S4=7, S5=8, G3=9.
- R2: In C0, a halt pulse moves the state to C1 and a level-2 read pulse moves it to C2.
- R3: In C0, a level-3 or level-4 read pulse moves the state to C3 when the C4-on-C3 bit is 0. When that bit is 1 it moves to C4, except that it moves to C3 when the bus-master gating bit is 1 and bus-master activity is 1.
- R4: In C0, a sleep-enable pulse moves the state to the sleep type requested on the 2-bit type input: 0 gives S1, 1 gives S3, 2 gives S4 and 3 gives S5.
- R5: A power-button override pulse in C0 or C1 moves the state to S5.
- R6: While power-fail is high, any state other than G3 moves to G3 at the next edge, and G3 is held for as long as power-fail stays high.
- R7: In C1 a break event returns the state to C0 and a stop-clock request moves it to C2. In C2 or C3 a break event returns the state to C0.
- R8: Clock-stop is 1 exactly in C2, C3 and C4. Processor-stop is 1 exactly in C3 and C4. Low-voltage is 1 only while in C4.
- R9: On entry to C4, processor-stop is 1 in the first C4 cycle while low-voltage is still 0. Low-voltage rises one cycle later.
- R10: A break event while the voltage is low drops low-voltage at the next edge. The state then stays C4 with processor-stop at 1 for RESTORE_CYC cycles in total before it becomes C0.
- R11: When power-fail falls in G3, the next state is S5 if the after-power-loss bit is 1 or the state before G3 was S5. Otherwise the next state is C0.
- R12: Events that arrive together are resolved in this order: power-fail, then power-button override, then sleep-enable, then idle triggers. Among the idle triggers in C0, a level-3/4 read wins over a level-2 read, which wins over a halt.
- R13: In a sleep state (S1, S3, S4), halt, level reads, break events and stop-clock requests leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_i | input | 1 | Processor halt pulse |
| lvl2_rd_i | input | 1 | Level-2 idle register read pulse |
| lvl3_rd_i | input | 1 | Level-3 idle register read pulse |
| lvl4_rd_i | input | 1 | Level-4 idle register read pulse |
| slp_en_i | input | 1 | Sleep-enable pulse |
| slp_typ_i | input | 2 | Requested sleep type (0 S1, 1 S3, 2 S4, 3 S5) |
| pwrbtn_ovr_i | input | 1 | Power-button override pulse |
| pwr_fail_i | input | 1 | Power failure or mechanical off, level |
| break_evt_i | input | 1 | Any enabled break event pulse |
| stpclk_req_i | input | 1 | Stop-clock request going active |
| c4onc3_en_i | input | 1 | Promote level-3/4 idle to C4 |
| bmz_en_i | input | 1 | Gate C4 promotion on bus-master activity |
| bm_active_i | input | 1 | Bus-master activity present |
| afterg3_i | input | 1 | After-power-loss: go to soft-off |
| state_o | output | 4 | Current state code |
| stpclk_o | output | 1 | Clock stop control |
| stpcpu_o | output | 1 | Processor stop control |
| lowv_o | output | 1 | Processor low-voltage request |

## Verification
A wrong state register shows on state_o at the first clock edge after the trigger. The control outputs are decoded from that register, so the same edge would also show a wrong clock-stop or processor-stop level. A fault in the deep-idle sequencer shows as low-voltage rising with no processor stop before it, or as processor-stop dropping earlier or later than RESTORE_CYC cycles after the restore. A lost record of the pre-loss state shows only when power returns, as C0 where S5 was due.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [3:0] {
    ST_C0 = 4'd0,
    ST_C1 = 4'd1,
    ST_C2 = 4'd2,
    ST_C3 = 4'd3,
    ST_C4 = 4'd4,
    ST_S1 = 4'd5,
    ST_S3 = 4'd6,
    ST_S4 = 4'd7,
    ST_S5 = 4'd8,
    ST_G3 = 4'd9
  } pst_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ENT  = 2'd1,
    PH_LOW  = 2'd2,
    PH_RST  = 2'd3
  } c4ph_e;

  function automatic pst_e sleep_target(input logic [1:0] typ);
    case (typ)
      2'd0:    sleep_target = ST_S1;
      2'd1:    sleep_target = ST_S3;
      2'd2:    sleep_target = ST_S4;
      default: sleep_target = ST_S5;
    endcase
  endfunction

endpackage

// File: rtl/pwr_idle_sel.sv
module pwr_idle_sel
  import pwr_state_pkg::*;
(
  input  logic c4onc3_en_i,
  input  logic bmz_en_i,
  input  logic bm_active_i,
  output pst_e deep_tgt_o
);

  always_comb begin
    if (!c4onc3_en_i)
      deep_tgt_o = ST_C3;
    else if (bmz_en_i && bm_active_i)
      deep_tgt_o = ST_C3;
    else
      deep_tgt_o = ST_C4;
  end

endmodule

// File: rtl/pwr_c4_seq.sv
module pwr_c4_seq
  import pwr_state_pkg::*;
#(
  parameter int RESTORE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_i,
  input  logic exit_req_i,
  input  logic abort_i,
  output logic low_o,
  output logic done_o
);

  localparam int CW = (RESTORE_CYC < 2) ? 1 : $clog2(RESTORE_CYC);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RESTORE_CYC - 1);

  c4ph_e          ph_q, ph_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (abort_i) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE: if (enter_i) ph_d = PH_ENT;
        PH_ENT:  ph_d = PH_LOW;
        PH_LOW: begin
          if (exit_req_i) begin
            ph_d   = PH_RST;
            cnt_d  = CNT_LOAD;
            cnt_en = 1'b1;
          end
        end
        PH_RST: begin
          if (cnt_q == '0) begin
            ph_d = PH_IDLE;
          end else begin
            cnt_d  = cnt_q - 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign low_o  = (ph_q == PH_LOW);
  assign done_o = (ph_q == PH_RST) && (cnt_q == '0);

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int RESTORE_CYC = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_i,
  input  logic       lvl2_rd_i,
  input  logic       lvl3_rd_i,
  input  logic       lvl4_rd_i,
  input  logic       slp_en_i,
  input  logic [1:0] slp_typ_i,
  input  logic       pwrbtn_ovr_i,
  input  logic       pwr_fail_i,
  input  logic       break_evt_i,
  input  logic       stpclk_req_i,
  input  logic       c4onc3_en_i,
  input  logic       bmz_en_i,
  input  logic       bm_active_i,
  input  logic       afterg3_i,
  output logic [3:0] state_o,
  output logic       stpclk_o,
  output logic       stpcpu_o,
  output logic       lowv_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_STAGES-1];

  pst_e st_q, st_d;
  logic pre_s5_q, pre_s5_d;
  pst_e deep_tgt;
  logic c4_low, c4_done;
  logic c4_enter, c4_exit, c4_abort;

  pwr_idle_sel u_idle_sel (
    .c4onc3_en_i (c4onc3_en_i),
    .bmz_en_i    (bmz_en_i),
    .bm_active_i (bm_active_i),
    .deep_tgt_o  (deep_tgt)
  );

  assign c4_enter = (st_d == ST_C4) && (st_q != ST_C4);
  assign c4_exit  = (st_q == ST_C4) && break_evt_i;
  assign c4_abort = (st_q == ST_C4) && pwr_fail_i;

  pwr_c4_seq #(.RESTORE_CYC(RESTORE_CYC)) u_c4_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .enter_i    (c4_enter),
    .exit_req_i (c4_exit),
    .abort_i    (c4_abort),
    .low_o      (c4_low),
    .done_o     (c4_done)
  );

  always_comb begin
    st_d     = st_q;
    pre_s5_d = pre_s5_q;
    if (st_q == ST_G3) begin
      if (!pwr_fail_i)
        st_d = (afterg3_i || pre_s5_q) ? ST_S5 : ST_C0;
    end else if (pwr_fail_i) begin
      st_d     = ST_G3;
      pre_s5_d = (st_q == ST_S5);
    end else if (pwrbtn_ovr_i && (st_q == ST_C0 || st_q == ST_C1)) begin
      st_d = ST_S5;
    end else begin
      case (st_q)
        ST_C0: begin
          if (slp_en_i)                    st_d = sleep_target(slp_typ_i);
          else if (lvl3_rd_i || lvl4_rd_i) st_d = deep_tgt;
          else if (lvl2_rd_i)              st_d = ST_C2;
          else if (halt_i)                 st_d = ST_C1;
        end
        ST_C1: begin
          if (break_evt_i)       st_d = ST_C0;
          else if (stpclk_req_i) st_d = ST_C2;
        end
        ST_C2, ST_C3: if (break_evt_i) st_d = ST_C0;
        ST_C4:        if (c4_done)     st_d = ST_C0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q     <= ST_C0;
      pre_s5_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      pre_s5_q <= pre_s5_d;
    end
  end

  assign state_o  = st_q;
  assign stpclk_o = (st_q == ST_C2) || (st_q == ST_C3) || (st_q == ST_C4);
  assign stpcpu_o = (st_q == ST_C3) || (st_q == ST_C4);
  assign lowv_o   = (st_q == ST_C4) && c4_low;

endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] state_o,
  input logic       stpcpu_o,
  input logic       lowv_o,
  input logic       pwr_fail_i,
  input logic       pwrbtn_ovr_i
);

  assert_lowv_needs_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lowv_o |-> (stpcpu_o && state_o == 4'd4));

  assert_stop_before_lowv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowv_o) |-> $past(stpcpu_o));

  assert_restore_before_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stpcpu_o) && state_o == 4'd0) |-> !$past(lowv_o));

  assert_fail_to_g3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> (state_o == 4'd9));

  assert_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrbtn_ovr_i && !pwr_fail_i && (state_o == 4'd0 || state_o == 4'd1)) |=> (state_o == 4'd8));

endmodule

bind pwr_state_ctrl pwr_state_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .state_o      (state_o),
  .stpcpu_o     (stpcpu_o),
  .lowv_o       (lowv_o),
  .pwr_fail_i   (pwr_fail_i),
  .pwrbtn_ovr_i (pwrbtn_ovr_i)
);

// File: tb/pwr_state_ctrl_test.sv
`timescale 1ns/1ps
module pwr_state_ctrl_test;

  localparam int RCYC = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       halt_i, lvl2_rd_i, lvl3_rd_i, lvl4_rd_i, slp_en_i;
  logic [1:0] slp_typ_i;
  logic       pwrbtn_ovr_i, pwr_fail_i, break_evt_i, stpclk_req_i;
  logic       c4onc3_en_i, bmz_en_i, bm_active_i, afterg3_i;
  logic [3:0] state_o;
  logic       stpclk_o, stpcpu_o, lowv_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pwr_state_ctrl #(.RESTORE_CYC(RCYC)) uut (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .lvl2_rd_i(lvl2_rd_i),
    .lvl3_rd_i(lvl3_rd_i), .lvl4_rd_i(lvl4_rd_i), .slp_en_i(slp_en_i),
    .slp_typ_i(slp_typ_i), .pwrbtn_ovr_i(pwrbtn_ovr_i), .pwr_fail_i(pwr_fail_i),
    .break_evt_i(break_evt_i), .stpclk_req_i(stpclk_req_i),
    .c4onc3_en_i(c4onc3_en_i), .bmz_en_i(bmz_en_i), .bm_active_i(bm_active_i),
    .afterg3_i(afterg3_i), .state_o(state_o), .stpclk_o(stpclk_o),
    .stpcpu_o(stpcpu_o), .lowv_o(lowv_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ctl(input string req, input int st, input int c, input int p, input int v);
    chk({req, " state"}, state_o, st);
    chk({req, " stpclk"}, stpclk_o, c);
    chk({req, " stpcpu"}, stpcpu_o, p);
    chk({req, " lowv"}, lowv_o, v);
  endtask

  task automatic clear_in();
    halt_i = 0; lvl2_rd_i = 0; lvl3_rd_i = 0; lvl4_rd_i = 0; slp_en_i = 0;
    slp_typ_i = 0; pwrbtn_ovr_i = 0; pwr_fail_i = 0; break_evt_i = 0;
    stpclk_req_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_in();
    c4onc3_en_i = 0; bmz_en_i = 0; bm_active_i = 0; afterg3_i = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  // inputs were set just after a falling edge; one rising edge later, clear and sample
  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_reset();
    do_reset();
    chk_ctl("R1 reset", 0, 0, 0, 0);
  endtask

  task automatic t_light();
    do_reset();
    halt_i = 1; step();
    chk("R2 halt->C1", state_o, 1);
    break_evt_i = 1; step();
    chk("R7 C1 break->C0", state_o, 0);
    lvl2_rd_i = 1; step();
    chk_ctl("R2/R8 lvl2->C2", 2, 1, 0, 0);
    break_evt_i = 1; step();
    chk("R7 C2 break->C0", state_o, 0);
    halt_i = 1; step();
    stpclk_req_i = 1; step();
    chk("R7 C1 stpclk->C2", state_o, 2);
  endtask

  task automatic t_deep();
    do_reset();
    lvl3_rd_i = 1; step();
    chk_ctl("R3/R8 c4onc3=0 -> C3", 3, 1, 1, 0);
    break_evt_i = 1; step();
    chk("R7 C3 break->C0", state_o, 0);
    c4onc3_en_i = 1; bmz_en_i = 1; bm_active_i = 1;
    lvl4_rd_i = 1; step();
    chk("R3 bm gated -> C3", state_o, 3);
    break_evt_i = 1; step();
    bmz_en_i = 0;
    lvl4_rd_i = 1; step();
    chk("R3 gate off -> C4", state_o, 4);
    do_reset();
    c4onc3_en_i = 1; bmz_en_i = 1; bm_active_i = 0;
    lvl3_rd_i = 1; step();
    chk("R3 bm idle -> C4", state_o, 4);
  endtask

  task automatic t_c4seq();
    do_reset();
    c4onc3_en_i = 1;
    lvl3_rd_i = 1; step();
    chk_ctl("R9 C4 first cycle", 4, 1, 1, 0);
    @(negedge clk);
    chk_ctl("R9 C4 low voltage", 4, 1, 1, 1);
    @(negedge clk);
    chk("R9 low held", lowv_o, 1);
    break_evt_i = 1; step();
    for (int i = 0; i < RCYC; i++) begin
      chk_ctl("R10 restore hold", 4, 1, 1, 0);
      @(negedge clk);
    end
    chk_ctl("R10 back to C0", 0, 0, 0, 0);
  endtask

  task automatic t_sleep();
    for (int t = 0; t < 4; t++) begin
      do_reset();
      slp_typ_i = 2'(t); slp_en_i = 1; step();
      chk("R4 sleep type", state_o, (t == 0) ? 5 : (t == 1) ? 6 : (t == 2) ? 7 : 8);
    end
    do_reset();
    slp_typ_i = 2'd1; slp_en_i = 1; step();
    halt_i = 1; step();
    lvl2_rd_i = 1; step();
    lvl4_rd_i = 1; step();
    break_evt_i = 1; step();
    stpclk_req_i = 1; step();
    chk_ctl("R13 S3 ignores idle triggers", 6, 0, 0, 0);
  endtask

  task automatic t_override();
    do_reset();
    pwrbtn_ovr_i = 1; step();
    chk("R5 override from C0", state_o, 8);
    do_reset();
    halt_i = 1; step();
    pwrbtn_ovr_i = 1; step();
    chk("R5 override from C1", state_o, 8);
  endtask

  task automatic t_g3();
    do_reset();
    lvl2_rd_i = 1; step();
    pwr_fail_i = 1; @(negedge clk);
    chk_ctl("R6 C2 fail -> G3", 9, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R6 G3 held", state_o, 9);
    pwr_fail_i = 0; @(negedge clk);
    chk("R11 return clear bit -> C0", state_o, 0);
    pwrbtn_ovr_i = 1; step();
    pwr_fail_i = 1; @(negedge clk);
    chk("R6 S5 fail -> G3", state_o, 9);
    pwr_fail_i = 0; @(negedge clk);
    chk("R11 return from prior S5 -> S5", state_o, 8);
    do_reset();
    afterg3_i = 1;
    pwr_fail_i = 1; @(negedge clk);
    pwr_fail_i = 0; @(negedge clk);
    chk("R11 afterg3 set -> S5", state_o, 8);
    do_reset();
    c4onc3_en_i = 1;
    lvl3_rd_i = 1; step();
    @(negedge clk);
    pwr_fail_i = 1; @(negedge clk);
    chk_ctl("R6 C4 low fail -> G3", 9, 0, 0, 0);
  endtask

  task automatic t_prio();
    do_reset();
    pwr_fail_i = 1; pwrbtn_ovr_i = 1; slp_en_i = 1; halt_i = 1; step();
    chk("R12 fail wins", state_o, 9);
    do_reset();
    pwrbtn_ovr_i = 1; slp_en_i = 1; slp_typ_i = 0; halt_i = 1; step();
    chk("R12 override over sleep", state_o, 8);
    do_reset();
    slp_en_i = 1; slp_typ_i = 0; lvl3_rd_i = 1; halt_i = 1; step();
    chk("R12 sleep over idle", state_o, 5);
    do_reset();
    lvl3_rd_i = 1; lvl2_rd_i = 1; halt_i = 1; step();
    chk("R12 lvl3 over lvl2/halt", state_o, 3);
    do_reset();
    lvl2_rd_i = 1; halt_i = 1; step();
    chk("R12 lvl2 over halt", state_o, 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0;
    clear_in();
    c4onc3_en_i = 0; bmz_en_i = 0; bm_active_i = 0; afterg3_i = 0;
    t_reset();
    t_light();
    t_deep();
    t_c4seq();
    t_sleep();
    t_override();
    t_g3();
    t_prio();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

endmodule